// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode and Wake-Up Controller

This block is the control core of a single-wire bus transceiver. It decodes two mode-select pins into four operating modes: sleep, high-speed download, high-voltage wake-up and normal. It adds a standby state between sleep and the active modes. Standby is entered at power-on, on a filtered bus wake-up, or when an active mode is left. It falls back to sleep after a timeout, and any accepted active mode cancels it. The block drives an inhibit output that keeps an external regulator on in every state except sleep. It signals a bus wake-up to the host as a low level on the receive-interrupt line.

All timing runs on a single tick strobe. The mode pins are synchronised and must show the same value on several consecutive ticks before a change is accepted. The bus wake comparator is synchronised and must stay high for a set number of ticks before it counts as a wake-up. The block also reports the effective mode and the driver controls that follow from it: transmit enable, wave shaping enable and high-voltage drive.

Top module: `swc_mode_ctrl`

## Requirements
- R1: The effective mode output `mode_o` uses the codes 0 = sleep, 1 = standby, 2 = high-speed, 3 = high-voltage wake-up and 4 = normal. `mode_sel[0]` is the first select pin. An accepted selection of 01 gives high-speed, 10 gives wake-up and 11 gives normal.
- R2: After reset the block is in standby (`mode_o` = 1), with `inh_o` high and `rxd_irq_n` high.
- R3: In standby with selection 00, the block enters sleep on exactly the SLEEP_TICKS-th tick counted since standby was entered. In sleep, `inh_o` is low.
- R4: An accepted non-00 selection moves the block from sleep, from standby or from another active mode straight to the selected mode, with `inh_o` high.
- R5: An accepted selection of 00 in an active mode enters standby with a fresh timeout. `inh_o` stays high until that timeout expires.
- R6: A wake-up is valid only when the synchronised wake level is high on WAKE_FILT_TICKS consecutive ticks. Any low level restarts the count, and a shorter pulse changes nothing.
- R7: A valid wake-up in sleep enters standby with `inh_o` high and `rxd_irq_n` low. `rxd_irq_n` returns high when an active mode is entered or when the block falls back to sleep.
- R8: A valid wake-up while in standby restarts the standby timeout and drives `rxd_irq_n` low.
- R9: `tx_en` is high only in modes 2, 3 and 4. `shape_en` is high only in modes 3 and 4.
- R10: `hv_drv` is high only in mode 3 while `low_batt` is low.
- R11: After two synchroniser flops, a new selection is accepted only when it has been sampled on MODE_HOLD_TICKS consecutive ticks. A value held for fewer ticks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; returns the block to power-on standby |
| tick | input | 1 | Timebase strobe, one cycle wide |
| mode_sel | input | 2 | Mode-select pins, asynchronous |
| wake_lvl | input | 1 | Bus above wake threshold, asynchronous |
| low_batt | input | 1 | Low-battery flag |
| mode_o | output | 3 | Effective mode code |
| inh_o | output | 1 | Regulator inhibit enable (high = regulator on) |
| rxd_irq_n | output | 1 | Wake-up interrupt, active low |
| tx_en | output | 1 | Transmitter may drive the bus |
| shape_en | output | 1 | Wave shaping enabled |
| hv_drv | output | 1 | High-voltage wake-up drive level selected |

## Verification
The main sweep walks every active selection to every selection, including a return to 00, once with `low_batt` low and once with it high. It compares all mode-dependent outputs against values computed from the pin code. This separates a wrong pin-to-mode mapping from a wrong output decode and from a missing low-battery override. The timeout is checked one tick before and at expiry, both after reset and after leaving an active mode. This exposes off-by-one errors and a timer that is not cleared on entry. Wake pulses one tick short, a pulse broken by a low level, and a wake-up in the middle of standby show whether the filter restarts its count and whether a wake-up rearms the timeout. A mode glitch held for a single tick shows whether the hold filter ignores it.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_STBY  = 3'd1,
        ST_HSPD  = 3'd2,
        ST_WAKE  = 3'd3,
        ST_NORM  = 3'd4
    } swc_state_e;

    // Map an accepted pin selection to the active mode it requests.
    function automatic swc_state_e swc_decode(input logic [1:0] sel);
        case (sel)
            2'b01:   return ST_HSPD;
            2'b10:   return ST_WAKE;
            2'b11:   return ST_NORM;
            default: return ST_STBY;
        endcase
    endfunction

endpackage

// File: rtl/swc_mode_filter.sv
module swc_mode_filter #(
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] pins_i,
    output logic [1:0] acc_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic [1:0]    sync1;
        logic [1:0]    sync2;
        logic [1:0]    cand;
        logic [HW-1:0] hold;
        logic [1:0]    acc;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pins_i;
        st_d.sync2 = st_q.sync1;
        if (tick) begin
            if (st_q.sync2 != st_q.cand) begin
                st_d.cand = st_q.sync2;
                st_d.hold = HW'(1);
                if (HOLD_TICKS == 1) begin
                    st_d.acc = st_q.sync2;
                end
            end else if (st_q.hold < HW'(HOLD_TICKS)) begin
                st_d.hold = st_q.hold + HW'(1);
                if (st_q.hold + HW'(1) == HW'(HOLD_TICKS)) begin
                    st_d.acc = st_q.cand;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync1: 2'b00, sync2: 2'b00, cand: 2'b00,
                      hold: HW'(HOLD_TICKS), acc: 2'b00};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/swc_wake_filter.sv
module swc_wake_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl_i,
    output logic evt_o
);
    localparam int CW = $clog2(FILT_TICKS + 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic [CW-1:0] cnt;
        logic          evt;
    } wake_t;

    wake_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = lvl_i;
        st_d.sync2 = st_q.sync1;
        st_d.evt   = 1'b0;
        if (!st_q.sync2) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt < CW'(FILT_TICKS))) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt == CW'(FILT_TICKS - 1)) begin
                st_d.evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

endmodule

// File: rtl/swc_mode_fsm.sv
module swc_mode_fsm
    import swc_pkg::*;
#(
    parameter int SLEEP_TICKS = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] acc_i,
    input  logic       wake_evt_i,
    output swc_state_e state_o,
    output logic       irq_o
);
    localparam int TW = $clog2(SLEEP_TICKS);
    localparam logic [TW-1:0] LAST = TW'(SLEEP_TICKS - 1);

    typedef struct packed {
        swc_state_e    state;
        logic [TW-1:0] timer;
        logic          irq;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_SLEEP, ST_STBY: begin
                if (acc_i != 2'b00) begin
                    st_d.state = swc_decode(acc_i);
                    st_d.irq   = 1'b0;
                end else if (wake_evt_i) begin
                    st_d.state = ST_STBY;
                    st_d.timer = '0;
                    st_d.irq   = 1'b1;
                end else if (tick && (st_q.state == ST_STBY)) begin
                    if (st_q.timer == LAST) begin
                        st_d.state = ST_SLEEP;
                        st_d.timer = '0;
                        st_d.irq   = 1'b0;
                    end else begin
                        st_d.timer = st_q.timer + TW'(1);
                    end
                end
            end
            default: begin
                if (acc_i == 2'b00) begin
                    st_d.state = ST_STBY;
                    st_d.timer = '0;
                end else begin
                    st_d.state = swc_decode(acc_i);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_STBY, timer: '0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.state;
    assign irq_o   = st_q.irq;

endmodule

// File: rtl/swc_mode_ctrl.sv
module swc_mode_ctrl
    import swc_pkg::*;
#(
    parameter int SLEEP_TICKS     = 25000,
    parameter int WAKE_FILT_TICKS = 4,
    parameter int MODE_HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode_sel,
    input  logic       wake_lvl,
    input  logic       low_batt,
    output logic [2:0] mode_o,
    output logic       inh_o,
    output logic       rxd_irq_n,
    output logic       tx_en,
    output logic       shape_en,
    output logic       hv_drv
);
    logic [1:0] acc_sel;
    logic       wake_evt;
    logic       irq;
    swc_state_e state;

    swc_mode_filter #(.HOLD_TICKS(MODE_HOLD_TICKS)) mode_filt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pins_i(mode_sel), .acc_o(acc_sel)
    );

    swc_wake_filter #(.FILT_TICKS(WAKE_FILT_TICKS)) wake_filt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lvl_i(wake_lvl), .evt_o(wake_evt)
    );

    swc_mode_fsm #(.SLEEP_TICKS(SLEEP_TICKS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .acc_i(acc_sel),
        .wake_evt_i(wake_evt), .state_o(state), .irq_o(irq)
    );

    assign mode_o    = state;
    assign inh_o     = (state != ST_SLEEP);
    assign rxd_irq_n = ~irq;
    assign tx_en     = (state == ST_HSPD) || (state == ST_WAKE) || (state == ST_NORM);
    assign shape_en  = (state == ST_WAKE) || (state == ST_NORM);
    assign hv_drv    = (state == ST_WAKE) && !low_batt;

endmodule

// File: rtl/swc_mode_ctrl_chk.sv
module swc_mode_ctrl_chk
    import swc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [2:0] mode_o,
    input logic       inh_o,
    input logic       rxd_irq_n
);
    // R3
    timeout_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == ST_STBY) |=> (mode_o != ST_SLEEP || $past(tick)));

    // R5
    inh_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inh_o) |-> ($past(mode_o) == ST_STBY));

    // R7
    wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == ST_SLEEP) |=> (mode_o != ST_STBY || !rxd_irq_n));

    // R8
    irq_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rxd_irq_n |-> (mode_o == ST_STBY));

    // R11
    mode_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o != $past(mode_o)) && (mode_o >= ST_HSPD)) |-> $past(tick, 2));

endmodule

bind swc_mode_ctrl swc_mode_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mode_o(mode_o), .inh_o(inh_o), .rxd_irq_n(rxd_irq_n)
);

// File: tb/swc_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module swc_mode_ctrl_tb_top;
    localparam int SL = 12;
    localparam int WF = 3;
    localparam int HD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       wake_lvl = 1'b0;
    logic       low_batt = 1'b0;
    logic [2:0] mode_o;
    logic       inh_o, rxd_irq_n, tx_en, shape_en, hv_drv;
    int         vecs = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    swc_mode_ctrl #(.SLEEP_TICKS(SL), .WAKE_FILT_TICKS(WF), .MODE_HOLD_TICKS(HD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
        .wake_lvl(wake_lvl), .low_batt(low_batt), .mode_o(mode_o), .inh_o(inh_o),
        .rxd_irq_n(rxd_irq_n), .tx_en(tx_en), .shape_en(shape_en), .hv_drv(hv_drv)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tk(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic set_pins(input logic [1:0] v);
        @(negedge clk) mode_sel = v;
        cyc(3);
    endtask

    task automatic set_wake(input logic v);
        @(negedge clk) wake_lvl = v;
        cyc(3);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Mode-dependent outputs computed from the mode code (R1, R9, R10).
    task automatic chk_mode(input string tag, input int m);
        check({tag, " mode"}, int'(mode_o), m);
        check({tag, " inh"}, int'(inh_o), (m != 0) ? 1 : 0);
        check({tag, " R9 tx_en"}, int'(tx_en), (m >= 2) ? 1 : 0);
        check({tag, " R9 shape_en"}, int'(shape_en), (m >= 3) ? 1 : 0);
        check({tag, " R10 hv_drv"}, int'(hv_drv), (m == 3 && !low_batt) ? 1 : 0);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        cyc(2);
        // R2
        chk_mode("R2 reset", 1);
        check("R2 irq", int'(rxd_irq_n), 1);

        // R3: timeout boundary after reset
        tk(SL - 1);
        chk_mode("R3 before timeout", 1);
        tk(1);
        chk_mode("R3 at timeout", 0);

        // R6: short pulse, then a pulse broken by a low level
        set_wake(1'b1);
        tk(WF - 1);
        chk_mode("R6 short pulse", 0);
        check("R6 irq", int'(rxd_irq_n), 1);
        set_wake(1'b0);
        set_wake(1'b1);
        tk(WF - 1);
        chk_mode("R6 restarted count", 0);
        tk(1);
        // R7
        chk_mode("R7 wake from sleep", 1);
        check("R7 irq low", int'(rxd_irq_n), 0);
        set_wake(1'b0);

        set_pins(2'b11);
        tk(HD);
        chk_mode("R7 active clears", 4);
        check("R7 irq cleared", int'(rxd_irq_n), 1);

        // R1 R4 R5 R9 R10: sweep of selections with and without low battery
        for (int lb = 0; lb < 2; lb++) begin
            for (int fr = 1; fr < 4; fr++) begin
                for (int to = 0; to < 4; to++) begin
                    @(negedge clk) low_batt = lb[0];
                    set_pins(fr[1:0]);
                    tk(HD);
                    chk_mode("R1 R4 from", fr + 1);
                    set_pins(to[1:0]);
                    tk(HD);
                    chk_mode("R1 R4 R5 to", (to == 0) ? 1 : to + 1);
                end
            end
        end
        @(negedge clk) low_batt = 1'b0;

        // R5: fresh timeout after leaving an active mode
        set_pins(2'b10);
        tk(HD);
        chk_mode("R5 wake mode", 3);
        set_pins(2'b00);
        tk(HD);
        chk_mode("R5 standby", 1);
        tk(SL - 1);
        chk_mode("R5 before timeout", 1);
        tk(1);
        chk_mode("R5 at timeout", 0);

        // R8: wake-up in standby restarts the timeout
        set_wake(1'b1);
        tk(WF);
        set_wake(1'b0);
        chk_mode("R8 woke", 1);
        tk(6);
        set_wake(1'b1);
        tk(WF);
        set_wake(1'b0);
        check("R8 irq low", int'(rxd_irq_n), 0);
        tk(SL - 1);
        chk_mode("R8 timeout restarted", 1);
        tk(1);
        chk_mode("R8 expired", 0);
        check("R7 irq cleared on sleep", int'(rxd_irq_n), 1);

        // R11: a one-tick glitch is ignored, a held value is accepted
        set_pins(2'b11);
        tk(1);
        chk_mode("R11 one tick", 0);
        set_pins(2'b00);
        tk(2);
        chk_mode("R11 glitch ignored", 0);
        set_pins(2'b11);
        tk(1);
        chk_mode("R11 first sample", 0);
        tk(1);
        chk_mode("R11 accepted", 4);

        // R10: the low-battery override acts on the wake-up drive level
        @(negedge clk) low_batt = 1'b1;
        set_pins(2'b10);
        tk(HD);
        chk_mode("R10 low battery", 3);
        @(negedge clk) low_batt = 1'b0;
        cyc(1);
        chk_mode("R10 battery ok", 3);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule